// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

A 32-pin general-purpose I/O port behind a small word-addressed register bus. Software sets each pin as input or output, writes the value driven on output pins and reads back the synchronized level of every pin. Every pin input passes through a two-stage synchronizer. A pin whose synchronized level differs from the level one cycle earlier has produced a rising or a falling edge.

Rising and falling edges each have their own enable register and their own sticky status register. A single write-only clear register releases pending status for both edge kinds at once. The port raises one interrupt line while any status bit is pending. A read-only summary register shows the same condition.

Pins 29 and 30 are wired to a differential peripheral, so they always share one direction. They become outputs only when both of their direction bits are set.

Top module: `gpio_edge_port`

Register offsets (word index on `bus_addr`): 0 direction (rw), 1 output data (rw), 2 input level (ro), 3 rising enable (rw), 4 falling enable (rw), 5 rising status (ro), 6 falling status (ro), 7 clear (wo), 8 summary (ro, bit 0).

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: Direction bit n set to 1 makes `pin_oe[n]` 1, and set to 0 makes it 0, for every pin other than 29 and 30. The direction register reads back the value written.
- R3: `pin_oe[29]` and `pin_oe[30]` are both 1 only when direction bits 29 and 30 are both 1. Otherwise both are 0. The direction register still reads back both bits as written.
- R4: The output data register (offset 1) drives `pin_out` and reads back the value written.
- R5: Offset 2 returns the level of `pin_in` delayed by the two-flop synchronizer.
- R6: Rising-status bit n (offset 5) becomes 1 when pin n goes from 0 to 1 while rising-enable bit n (offset 3) is 1. A rising edge on a pin whose enable bit is 0 leaves its status bit at 0.
- R7: Falling-status bit n (offset 6) becomes 1 when pin n goes from 1 to 0 while falling-enable bit n (offset 4) is 1. A falling edge on a pin whose enable bit is 0 leaves its status bit at 0.
- R8: Status bits stay set until a 1 is written to the same bit of the clear register (offset 7). That write clears both the rising and the falling status bit of the pin. Reads of offset 7 return 0.
- R9: When an enabled edge and a clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when any rising or falling status bit is 1. Bit 0 of offset 8 reads the same value.
- R11: Read data appears on `bus_rdata` one clock after the read request. Writes to read-only offsets (2, 5, 6, 8) change nothing. Reads of offsets 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data for the pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Port interrupt |

## Verification
If a status bit is wrongly set or lost, the status reads show it on the next bus access, and `irq` shows it in the cycle after the faulty update. A synchronizer or edge stage that is off by one cycle moves status capture by one clock. The bench therefore reads status exactly three clocks after a pin change. A fault in the pair rule shows at once on `pin_oe[30:29]` when the direction bits disagree. A set-versus-clear priority fault only shows in the single cycle where an edge meets a clear, so that cycle is aimed at directly.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4,
  parameter int PAIR_A = 29,
  parameter int PAIR_B = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DIR = 0, A_OUT = 1, A_IN = 2, A_REN = 3,
    A_FEN = 4, A_RST = 5, A_FST = 6, A_CLR = 7, A_SUM = 8;

  logic [WIDTH-1:0] dir_q, out_q, ren_q, fen_q, rise_st, fall_st;
  logic [WIDTH-1:0] sync1, sync2, prev;
  logic [WIDTH-1:0] rise_ev, fall_ev, clr_mask;
  logic             wr_en, rd_en, pair_out;

  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign clr_mask = (wr_en && bus_addr == A_CLR) ? bus_wdata : '0;
  assign rise_ev  = sync2 & ~prev;
  assign fall_ev  = prev & ~sync2;
  assign pair_out = dir_q[PAIR_A] & dir_q[PAIR_B];
  assign irq      = |{rise_st, fall_st};
  assign pin_out  = out_q;

  always_comb begin
    pin_oe         = dir_q;
    pin_oe[PAIR_A] = pair_out;
    pin_oe[PAIR_B] = pair_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_DIR:   dir_q <= bus_wdata;
        A_OUT:   out_q <= bus_wdata;
        A_REN:   ren_q <= bus_wdata;
        A_FEN:   fen_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_st <= '0;
      fall_st <= '0;
    end else begin
      rise_st <= (rise_st & ~clr_mask) | (rise_ev & ren_q);
      fall_st <= (fall_st & ~clr_mask) | (fall_ev & fen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en) begin
      case (bus_addr)
        A_DIR:   bus_rdata <= dir_q;
        A_OUT:   bus_rdata <= out_q;
        A_IN:    bus_rdata <= sync2;
        A_REN:   bus_rdata <= ren_q;
        A_FEN:   bus_rdata <= fen_q;
        A_RST:   bus_rdata <= rise_st;
        A_FST:   bus_rdata <= fall_st;
        A_SUM:   bus_rdata <= {{(WIDTH-1){1'b0}}, irq};
        default: bus_rdata <= '0;
      endcase
    end else bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  ren_q,
  input logic [WIDTH-1:0]  rise_st,
  input logic [WIDTH-1:0]  fall_st,
  input logic              irq
);
  // R3
  pair_same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[29] == pin_oe[30]);
  // R3
  pair_both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[30] |-> (dir_q[29] && dir_q[30]));
  // R8
  rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 7) |=> ((rise_st & $past(rise_st)) == $past(rise_st)));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_sel && bus_wr && bus_addr == 7)) |=> irq);
  // R6
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_st & ~$past(rise_st) & ~$past(ren_q)) == '0));
  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr > 8) |=> bus_rdata == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
  .dir_q(dir_q), .ren_q(ren_q), .rise_st(rise_st), .fall_st(fall_st),
  .irq(irq));

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  logic        clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] r;

  always #2 clk = ~clk;

  gpio_edge_port dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // {pins, expected rising status, expected falling status}, starting from all pins low
  localparam logic [95:0] VEC [5] = '{
    {32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},
    {32'h0000_0F0F, 32'h0000_0F00, 32'h0000_00F0},
    {32'hA000_0000, 32'hA000_0000, 32'h0000_0F0F},
    {32'h8000_0001, 32'h0000_0001, 32'h2000_0000},
    {32'h0000_0000, 32'h0000_0000, 32'h8000_0001}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk); pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 oe", pin_oe, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], r); check("R1 reg", r, 0);
    end

    // Vector table: R6 R7 R10 R5 R8
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) begin
      wr(7, 32'hFFFF_FFFF);
      pins(VEC[i][95:64]);
      check("R10 irq", {31'b0, irq}, {31'b0, (VEC[i][63:0] != 0)});
      rd(5, r); check("R6 rise", r, VEC[i][63:32]);
      rd(6, r); check("R7 fall", r, VEC[i][31:0]);
      rd(8, r); check("R10 summary", r, {31'b0, (VEC[i][63:0] != 0)});
      rd(2, r); check("R5 input", r, VEC[i][95:64]);
    end
    wr(7, 32'hFFFF_FFFF);
    rd(7, r); check("R8 clear reads 0", r, 0);
    check("R10 irq cleared", {31'b0, irq}, 0);

    // R6 R7 enable masking
    wr(3, 32'h0000_000F); wr(4, 32'h0);
    pins(32'h0000_00FF);
    rd(5, r); check("R6 masked rise", r, 32'h0000_000F);
    pins(32'h0);
    rd(6, r); check("R7 disabled fall", r, 0);
    // R8 partial clear, sticky through more edges
    wr(7, 32'h0000_0003);
    rd(5, r); check("R8 partial clear", r, 32'h0000_000C);
    wr(7, 32'hFFFF_FFFF);

    // R8 clear hits both kinds; R9 set beats clear
    wr(3, 32'h20); wr(4, 32'h20);
    pins(32'h20);
    pins(32'h0);
    @(negedge clk); pin_in = 32'h20;
    @(negedge clk);
    wr(7, 32'h20);
    rd(5, r); check("R9 set wins", r, 32'h20);
    rd(6, r); check("R8 fall cleared", r, 0);
    wr(7, 32'h20);
    rd(5, r); check("R8 rise cleared", r, 0);
    check("R10 irq low", {31'b0, irq}, 0);

    // R2 direction
    wr(0, 32'h0000_F00F);
    check("R2 oe", pin_oe, 32'h0000_F00F);
    rd(0, r); check("R2 readback", r, 32'h0000_F00F);
    // R3 pair rule
    wr(0, 32'h2000_0000);
    check("R3 one bit", pin_oe, 0);
    wr(0, 32'h4000_0001);
    check("R3 other bit", pin_oe, 32'h0000_0001);
    rd(0, r); check("R3 readback", r, 32'h4000_0001);
    wr(0, 32'h6000_0000);
    check("R3 both", pin_oe, 32'h6000_0000);

    // R4 output data
    wr(1, 32'hDEAD_BEEF);
    check("R4 pin_out", pin_out, 32'hDEAD_BEEF);
    rd(1, r); check("R4 readback", r, 32'hDEAD_BEEF);

    // R11 read-only writes ignored, unmapped reads, latency
    wr(5, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF);
    rd(5, r); check("R11 ro rise", r, 0);
    rd(6, r); check("R11 ro fall", r, 0);
    check("R11 irq", {31'b0, irq}, 0);
    wr(15, 32'hFFFF_FFFF);
    rd(15, r); check("R11 unmapped", r, 0);
    rd(12, r); check("R11 unmapped", r, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 1;
    check("R11 no data before edge", bus_rdata, 0);
    @(negedge clk); bus_sel = 0;
    check("R11 data after one cycle", bus_rdata, 32'hDEAD_BEEF);

    finish_run();
  end
endmodule